// File: doc/BRIEF.md
# Transfer-Unit Slot Scheduler

This block runs in the link-clock domain and cuts the main-link symbol stream into fixed-length transfer units. Every link cycle it marks the current slot as either a data slot or a stuffing slot. Inside a unit the data slots come first and the stuffing slots fill the rest. The unit length, the number of data slots per unit and a start-of-line hold-off come from two configuration words plus a separate length field.

When moderation is on, the scheduler alternates two kinds of group. An upper group is a set number of units that each carry N data slots. A lower group is a set number of units that each carry the programmed lower count, normally N-1. The two groups repeat in that order, so the average data rate per unit can take a fractional value. A line-start pulse restarts the pattern: the hold-off runs first, then the upper group begins again.

The block also counts the units completed in the current line. Configuration is taken in only while the scheduler is idle, and a bad configuration keeps it idle. A fallback input replaces all programmed values with a safe default.

Top module: `tu_slot_scheduler`

## Requirements
- R1: The unit length is `tu_len_m1` + 1 link cycles, covering 32 to 64. `unit_last` is high on the final slot of every unit.
- R2: Within a unit, `slot_valid` is high for the first V slots and `slot_fill` is high for the remaining length minus V slots. V is the data count of the current unit. The two flags are never high together, and both are low whenever the scheduler is not emitting units.
- R3: After an accepted line start, no slot is emitted for D link cycles. D is `cfg_word1[31:16]`. The first slot of unit 0 appears in the D-th cycle after the accepting edge, and D = 0 means the very next cycle.
- R4: Moderation is enabled by `cfg_word2[0]`. When it is on, units 0 .. H-1 of a line use the upper data count `cfg_word1[7:0]`. The next L units use the lower count `cfg_word2[7:1]`. The cycle of H upper and L lower units then repeats. H is `cfg_word2[19:16]` and L is `cfg_word2[23:20]`. When moderation is off, every unit uses the upper count.
- R5: A line-start pulse accepted while units are running restarts the line. The hold-off runs again, the slot position returns to 0, the group sequence returns to an upper group, and the unit count returns to 0.
- R6: `unit_count` goes up by one after each completed unit and holds otherwise. It is cleared when a line start is accepted.
- R7: While `fallback` is high, the configuration taken in is a length of 32, a data count of 32, a hold-off of 0 and moderation off, whatever the words hold. `cfg_err` is 0 in this case.
- R8: Configuration inputs are taken in only while idle. Changes made while a line is running have no effect on the slot pattern, including the pattern after a restart.
- R9: `cfg_err` is set when any of these holds: the upper count exceeds the unit length; moderation is on and the lower count exceeds the length; moderation is on and either group count is 0; any reserved bit is nonzero. The reserved bits are word 1 [15:8], word 2 [15:8] and word 2 [31:24]. While `cfg_err` is set, line starts are ignored.
- R10: Driving `enable` low returns the scheduler to idle on the next cycle, with all slot flags low. Line starts are ignored while `enable` is low.
- R11: After reset the scheduler is idle, with `unit_count` = 0 and all slot flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run permission; low forces idle |
| fallback | input | 1 | Use the built-in safe configuration |
| line_start | input | 1 | Start-of-line pulse |
| tu_len_m1 | input | 6 | Unit length minus one |
| cfg_word1 | input | 32 | Upper data count [7:0], hold-off [31:16] |
| cfg_word2 | input | 32 | Moderation enable [0], lower count [7:1], upper group count [19:16], lower group count [23:20] |
| slot_valid | output | 1 | Current slot carries data |
| slot_fill | output | 1 | Current slot is stuffing |
| unit_last | output | 1 | Current slot is the last of its unit |
| unit_count | output | 16 | Units completed in the current line |
| cfg_err | output | 1 | Captured configuration is illegal |

## Verification
The bench uses the package's default field widths. A 6-bit length field covers every legal unit length from 32 to 64. The 4-bit group counts reach 15, so a full 15-upper/15-lower cycle of 30 units fits within one line. The bench sweeps several unit lengths against full, half and single data counts, with moderation off and with small and maximal group pairs, and it rotates the hold-off through 0, 1 and 7. Every slot's flags and the unit count are predicted from the slot index alone.

// File: rtl/tu_sched_pkg.sv
package tu_sched_pkg;

    localparam int WORD_W       = 32;
    localparam int SIZE_FLD_W   = 6;
    localparam int SIZE_W       = SIZE_FLD_W + 1;
    localparam int VAL_W        = 8;
    localparam int LOVAL_W      = 7;
    localparam int DLY_W        = 16;
    localparam int GRP_W        = 4;
    localparam int CNT_W        = 16;

    // field placement inside the two configuration words
    localparam int W1_VAL_LSB   = 0;
    localparam int W1_DLY_LSB   = 16;
    localparam int W2_EN_BIT    = 0;
    localparam int W2_LOVAL_LSB = 1;
    localparam int W2_HIGRP_LSB = 16;
    localparam int W2_LOGRP_LSB = 20;

    // reserved ranges derived from the field placement
    localparam int W1_RSV_LO    = W1_VAL_LSB + VAL_W;
    localparam int W1_RSV_HI    = W1_DLY_LSB - 1;
    localparam int W2_RSVA_LO   = W2_LOVAL_LSB + LOVAL_W;
    localparam int W2_RSVA_HI   = W2_HIGRP_LSB - 1;
    localparam int W2_RSVB_LO   = W2_LOGRP_LSB + GRP_W;
    localparam int W2_RSVB_HI   = WORD_W - 1;

    // safe default used in fallback mode
    localparam int FB_SIZE      = 32;
    localparam int FB_VALID     = 32;

    typedef enum logic [1:0] {
        SCH_IDLE,
        SCH_WAIT,
        SCH_RUN
    } sch_state_e;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic [VAL_W-1:0]  hi_valid;
        logic [VAL_W-1:0]  lo_valid;
        logic [DLY_W-1:0]  delay;
        logic              mod_en;
        logic [GRP_W-1:0]  hi_grp;
        logic [GRP_W-1:0]  lo_grp;
    } tu_cfg_t;

endpackage

// File: rtl/tu_cfg_capture.sv
module tu_cfg_capture
    import tu_sched_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap_en,
    input  logic                  fallback,
    input  logic [SIZE_FLD_W-1:0] size_m1,
    input  logic [WORD_W-1:0]     word1,
    input  logic [WORD_W-1:0]     word2,
    output tu_cfg_t               cfg,
    output logic                  cfg_err
);

    typedef struct packed {
        tu_cfg_t cfg;
        logic    err;
    } cap_state_t;

    localparam tu_cfg_t CFG_SAFE = '{
        size:     SIZE_W'(FB_SIZE),
        hi_valid: VAL_W'(FB_VALID),
        lo_valid: VAL_W'(FB_VALID - 1),
        delay:    '0,
        mod_en:   1'b0,
        hi_grp:   GRP_W'(1),
        lo_grp:   GRP_W'(1)
    };

    cap_state_t st_d, st_q;
    tu_cfg_t    dec;
    logic       rsv_set;
    logic       bad;

    always_comb begin
        dec.size     = {1'b0, size_m1} + SIZE_W'(1);
        dec.hi_valid = word1[W1_VAL_LSB +: VAL_W];
        dec.delay    = word1[W1_DLY_LSB +: DLY_W];
        dec.mod_en   = word2[W2_EN_BIT];
        dec.lo_valid = VAL_W'(word2[W2_LOVAL_LSB +: LOVAL_W]);
        dec.hi_grp   = word2[W2_HIGRP_LSB +: GRP_W];
        dec.lo_grp   = word2[W2_LOGRP_LSB +: GRP_W];

        rsv_set = (|word1[W1_RSV_HI:W1_RSV_LO])
                | (|word2[W2_RSVA_HI:W2_RSVA_LO])
                | (|word2[W2_RSVB_HI:W2_RSVB_LO]);

        bad = rsv_set
            || (dec.hi_valid > VAL_W'(dec.size))
            || (dec.mod_en && ((dec.lo_valid > VAL_W'(dec.size))
                               || (dec.hi_grp == '0)
                               || (dec.lo_grp == '0)));

        if (fallback) begin
            dec = CFG_SAFE;
            bad = 1'b0;
        end

        st_d = st_q;
        if (cap_en) begin
            st_d.cfg = dec;
            st_d.err = bad;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg <= CFG_SAFE;
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg     = st_q.cfg;
    assign cfg_err = st_q.err;

endmodule

// File: rtl/tu_group_seq.sv
module tu_group_seq
    import tu_sched_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             unit_done,
    input  logic             mod_en,
    input  logic [VAL_W-1:0] hi_valid,
    input  logic [VAL_W-1:0] lo_valid,
    input  logic [GRP_W-1:0] hi_grp,
    input  logic [GRP_W-1:0] lo_grp,
    output logic [VAL_W-1:0] cur_valid
);

    typedef struct packed {
        logic             in_lower;
        logic [GRP_W-1:0] done_in_grp;
    } grp_state_t;

    grp_state_t st_d, st_q;
    logic [GRP_W-1:0] grp_len;
    logic [GRP_W-1:0] done_inc;

    always_comb begin
        st_d     = st_q;
        grp_len  = st_q.in_lower ? lo_grp : hi_grp;
        done_inc = st_q.done_in_grp + GRP_W'(1);

        if (restart) begin
            st_d.in_lower    = 1'b0;
            st_d.done_in_grp = '0;
        end else if (unit_done && mod_en) begin
            if (done_inc == grp_len) begin
                st_d.in_lower    = ~st_q.in_lower;
                st_d.done_in_grp = '0;
            end else begin
                st_d.done_in_grp = done_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_valid = (mod_en && st_q.in_lower) ? lo_valid : hi_valid;

endmodule

// File: rtl/tu_slot_gen.sv
module tu_slot_gen
    import tu_sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              line_start,
    input  logic              cfg_err,
    input  logic [SIZE_W-1:0] size,
    input  logic [DLY_W-1:0]  delay,
    input  logic [VAL_W-1:0]  cur_valid,
    output logic              accept,
    output logic              cap_en,
    output logic              unit_done,
    output logic              slot_valid,
    output logic              slot_fill,
    output logic [CNT_W-1:0]  unit_count
);

    typedef struct packed {
        sch_state_e        mode;
        logic [DLY_W-1:0]  dly;
        logic [SIZE_W-1:0] pos;
        logic [CNT_W-1:0]  units;
    } gen_state_t;

    gen_state_t st_d, st_q;
    logic       running;
    logic       in_data;

    always_comb begin
        running   = (st_q.mode == SCH_RUN);
        unit_done = running && (st_q.pos == size - SIZE_W'(1));
        accept    = enable && line_start && !cfg_err;
        cap_en    = (st_q.mode == SCH_IDLE) && !accept;
        in_data   = VAL_W'(st_q.pos) < cur_valid;

        st_d = st_q;

        if (!enable) begin
            st_d.mode = SCH_IDLE;
            st_d.pos  = '0;
        end else if (accept) begin
            st_d.pos = '0;
            if (delay == '0) begin
                st_d.mode = SCH_RUN;
            end else begin
                st_d.mode = SCH_WAIT;
                st_d.dly  = delay;
            end
        end else begin
            case (st_q.mode)
                SCH_WAIT: begin
                    if (st_q.dly == DLY_W'(1)) begin
                        st_d.mode = SCH_RUN;
                    end else begin
                        st_d.dly = st_q.dly - DLY_W'(1);
                    end
                end
                SCH_RUN: begin
                    st_d.pos = unit_done ? '0 : st_q.pos + SIZE_W'(1);
                end
                default: st_d.mode = SCH_IDLE;
            endcase
        end

        if (accept) begin
            st_d.units = '0;
        end else if (unit_done) begin
            st_d.units = st_q.units + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode  <= SCH_IDLE;
            st_q.dly   <= '0;
            st_q.pos   <= '0;
            st_q.units <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_valid = running && in_data;
    assign slot_fill  = running && !in_data;
    assign unit_count = st_q.units;

endmodule

// File: rtl/tu_slot_scheduler.sv
module tu_slot_scheduler
    import tu_sched_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  fallback,
    input  logic                  line_start,
    input  logic [SIZE_FLD_W-1:0] tu_len_m1,
    input  logic [WORD_W-1:0]     cfg_word1,
    input  logic [WORD_W-1:0]     cfg_word2,
    output logic                  slot_valid,
    output logic                  slot_fill,
    output logic                  unit_last,
    output logic [CNT_W-1:0]      unit_count,
    output logic                  cfg_err
);

    tu_cfg_t          cfg;
    logic             accept;
    logic             cap_en;
    logic             unit_done;
    logic [VAL_W-1:0] cur_valid;

    tu_cfg_capture u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .fallback(fallback),
        .size_m1 (tu_len_m1),
        .word1   (cfg_word1),
        .word2   (cfg_word2),
        .cfg     (cfg),
        .cfg_err (cfg_err)
    );

    tu_group_seq u_grp (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (accept),
        .unit_done(unit_done),
        .mod_en   (cfg.mod_en),
        .hi_valid (cfg.hi_valid),
        .lo_valid (cfg.lo_valid),
        .hi_grp   (cfg.hi_grp),
        .lo_grp   (cfg.lo_grp),
        .cur_valid(cur_valid)
    );

    tu_slot_gen u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .line_start(line_start),
        .cfg_err   (cfg_err),
        .size      (cfg.size),
        .delay     (cfg.delay),
        .cur_valid (cur_valid),
        .accept    (accept),
        .cap_en    (cap_en),
        .unit_done (unit_done),
        .slot_valid(slot_valid),
        .slot_fill (slot_fill),
        .unit_count(unit_count)
    );

    assign unit_last = unit_done;

endmodule

// File: rtl/tu_sched_checker.sv
module tu_sched_checker
    import tu_sched_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             line_start,
    input logic             slot_valid,
    input logic             slot_fill,
    input logic             unit_last,
    input logic [CNT_W-1:0] unit_count,
    input logic             cfg_err
);

    AST_SLOT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot_valid && slot_fill)); // R2

    AST_FILL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_fill && !unit_last && !line_start) |=> !slot_valid); // R2

    AST_LAST_IN_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        unit_last |-> (slot_valid || slot_fill)); // R1

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_last && !line_start) |=> (unit_count == CNT_W'($past(unit_count) + 1))); // R6

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!unit_last && !line_start) |=> $stable(unit_count)); // R6

    AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && enable && !cfg_err) |=> (unit_count == '0)); // R5

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid || slot_fill) |=> $stable(cfg_err)); // R8

    AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !(slot_valid || slot_fill)); // R9

    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !(slot_valid || slot_fill || unit_last)); // R10

endmodule

bind tu_slot_scheduler tu_sched_checker u_sched_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .line_start(line_start),
    .slot_valid(slot_valid),
    .slot_fill (slot_fill),
    .unit_last (unit_last),
    .unit_count(unit_count),
    .cfg_err   (cfg_err)
);

// File: tb/tu_slot_scheduler_bench.sv
module tu_slot_scheduler_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic        fallback;
    logic        line_start;
    logic [5:0]  tu_len_m1;
    logic [31:0] cfg_word1;
    logic [31:0] cfg_word2;
    logic        slot_valid;
    logic        slot_fill;
    logic        unit_last;
    logic [15:0] unit_count;
    logic        cfg_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    int e_size, e_val, e_lval, e_dly, e_mod, e_up, e_lo;

    always #10 clk = ~clk;

    tu_slot_scheduler u_tu_slot_scheduler (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .fallback  (fallback),
        .line_start(line_start),
        .tu_len_m1 (tu_len_m1),
        .cfg_word1 (cfg_word1),
        .cfg_word2 (cfg_word2),
        .slot_valid(slot_valid),
        .slot_fill (slot_fill),
        .unit_last (unit_last),
        .unit_count(unit_count),
        .cfg_err   (cfg_err)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s got=%0d exp=%0d t=%0t", tag, what, got, exp, $time);
        end
    endtask

    // drive words from expected values; reserved bits zero
    task automatic set_words(input int size, input int v, input int lv, input int dly,
                             input int md, input int up, input int lo);
        e_size = size; e_val = v; e_lval = lv; e_dly = dly;
        e_mod = md; e_up = up; e_lo = lo;
        tu_len_m1 = 6'(size - 1);
        cfg_word1 = {16'(dly), 8'h00, 8'(v)};
        cfg_word2 = {8'h00, 4'(lo), 4'(up), 8'h00, 7'(lv), 1'(md)};
    endtask

    // go idle long enough for a capture, then re-enable
    task automatic load_words();
        @(negedge clk) enable = 1'b0;
        repeat (3) @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic check_cycle(input int k, input string tag_in);
        int j, u, p, vc, ev, el, ec;
        bit lowerf;
        string tv, tl, tc;
        if (k < e_dly) begin
            ev = 0; el = 0; ec = 0;
            tv = "R3"; tl = "R3"; tc = "R3";
            chk(tv, "fill", int'(slot_fill), 0);
        end else begin
            j = k - e_dly;
            u = j / e_size;
            p = j % e_size;
            lowerf = (e_mod != 0) && ((u % (e_up + e_lo)) >= e_up);
            vc = lowerf ? e_lval : e_val;
            ev = (p < vc) ? 1 : 0;
            el = (p == e_size - 1) ? 1 : 0;
            ec = u % 65536;
            tv = (e_mod != 0) ? "R4" : "R2";
            tl = "R1"; tc = "R6";
            chk((e_mod != 0) ? "R4" : "R2", "fill", int'(slot_fill), 1 - ev);
        end
        if (tag_in != "") begin tv = tag_in; tl = tag_in; tc = tag_in; end
        chk(tv, "valid", int'(slot_valid), ev);
        chk(tl, "last", int'(unit_last), el);
        chk(tc, "count", int'(unit_count), ec);
    endtask

    task automatic run_line(input int ncyc, input int chg_at, input string tag);
        @(negedge clk) line_start = 1'b1;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            line_start = 1'b0;
            if (k == chg_at) begin
                tu_len_m1 = 6'd40;
                cfg_word1 = 32'h0003_0011;
                cfg_word2 = 32'h0020_0003;
            end
            check_cycle(k, tag);
        end
    endtask

    task automatic chk_quiet(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(tag, "quiet valid", int'(slot_valid), 0);
            chk(tag, "quiet fill", int'(slot_fill), 0);
            chk(tag, "quiet last", int'(unit_last), 0);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        int sizes [4];
        int dlys [3];
        int mods [4];
        int ups [4];
        int los [4];
        int idx;
        int vals [3];
        int units;
        sizes = '{32, 37, 48, 64};
        dlys  = '{0, 1, 7};
        mods  = '{0, 1, 1, 1};
        ups   = '{1, 1, 3, 15};
        los   = '{1, 1, 2, 15};

        rst_n = 1'b0; enable = 1'b0; fallback = 1'b0; line_start = 1'b0;
        set_words(32, 32, 31, 0, 0, 1, 1);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "valid", int'(slot_valid), 0);
        chk("R11", "fill", int'(slot_fill), 0);
        chk("R11", "last", int'(unit_last), 0);
        chk("R11", "count", int'(unit_count), 0);
        chk("R11", "err", int'(cfg_err), 0);

        // sweep of lengths, data counts, moderation shapes and hold-offs (R1..R4, R6)
        idx = 0;
        for (int si = 0; si < 4; si++) begin
            vals = '{sizes[si], sizes[si] / 2 + 1, 1};
            for (int vi = 0; vi < 3; vi++) begin
                for (int mi = 0; mi < 4; mi++) begin
                    set_words(sizes[si], vals[vi], vals[vi] - 1, dlys[idx % 3],
                              mods[mi], ups[mi], los[mi]);
                    idx++;
                    load_words();
                    chk("R9", "err legal", int'(cfg_err), 0);
                    units = (mods[mi] != 0) ? (ups[mi] + los[mi] + 2) : 3;
                    run_line(e_dly + e_size * units, -1, "");
                end
            end
        end

        // R8 and R5: change inputs mid-line, then restart mid lower unit
        set_words(32, 20, 19, 3, 1, 1, 1);
        load_words();
        run_line(3 + 45, 5, "R8");
        run_line(3 + 32 * 3 + 3, -1, "R5");

        // R10: dropping enable idles the block; line starts ignored while low
        set_words(40, 25, 24, 2, 0, 1, 1);
        load_words();
        run_line(20, -1, "");
        @(negedge clk) enable = 1'b0;
        chk_quiet(1, "R10");
        line_start = 1'b1;
        chk_quiet(3, "R10");
        line_start = 1'b0;
        enable = 1'b1;
        chk_quiet(2, "R10");

        // R9: data count above length
        set_words(32, 33, 32, 0, 0, 1, 1);
        load_words();
        chk("R9", "err count", int'(cfg_err), 1);
        @(negedge clk) line_start = 1'b1;
        chk_quiet(1, "R9");
        line_start = 1'b0;
        chk_quiet(8, "R9");

        // R9: zero group count with moderation
        set_words(48, 10, 9, 0, 1, 0, 2);
        load_words();
        chk("R9", "err grp", int'(cfg_err), 1);

        // R9: reserved bit set
        set_words(48, 10, 9, 0, 0, 1, 1);
        cfg_word1[9] = 1'b1;
        load_words();
        chk("R9", "err rsv", int'(cfg_err), 1);
        cfg_word2[27] = 1'b1;
        cfg_word1[9] = 1'b0;
        load_words();
        chk("R9", "err rsv2", int'(cfg_err), 1);

        // legal again clears the flag; exact-fit count is legal
        set_words(64, 64, 63, 0, 1, 2, 1);
        load_words();
        chk("R9", "err clear", int'(cfg_err), 0);
        run_line(64 * 4, -1, "");

        // R7: fallback overrides illegal words
        set_words(33, 60, 60, 9, 1, 0, 0);
        cfg_word1[12] = 1'b1;
        fallback = 1'b1;
        load_words();
        chk("R7", "err", int'(cfg_err), 0);
        e_size = 32; e_val = 32; e_lval = 31; e_dly = 0; e_mod = 0; e_up = 1; e_lo = 1;
        run_line(32 * 3 + 5, -1, "R7");
        fallback = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not finish got=0 exp=1");
            summary();
            $finish;
        end
    end

endmodule